// File: doc/BRIEF.md
# Configuration Controller Register Unit

This unit is the software-visible register set of a fabric configuration controller. A host reaches it over a simple 32-bit bus. Each write presents a byte offset and a data word for one cycle. Reads return the addressed word combinationally in the same cycle. The unit holds these registers:

- a control register, which drives the active-low program line and the configuration-port select;
- a sticky interrupt status register;
- an interrupt mask;
- a read-only status word;
- an unlock register.

Edges on the external init and done lines are caught and recorded as sticky status bits. Pulses from the neighbouring DMA engine and bus logic are recorded in the same way. One level interrupt output flags any recorded event whose mask bit is clear. A second output flags any recorded event in the error group.

Write protection is held by a two-state lock machine. State `LK_SHUT` is entered at reset. In this state every bus write is discarded, except the unlock word written to the unlock offset. That write is transition `T_OPEN`, and it moves the machine to state `LK_OPEN`. State `LK_OPEN` has only transition `T_STAY`, so writes remain enabled until the next reset. No transition leads back to `LK_SHUT`.

Top module: `cfgreg_unit`

## Requirements
- R1: After reset the control register reads 0x00006000, interrupt status reads 0, the mask reads 0xFFFFFFFF, `irq` is 0, and the lock machine is in `LK_SHUT`.
- R2: In `LK_SHUT`, writes to control (0x000), interrupt status (0x00C) and mask (0x010) change nothing. Writing 0x757BDF0D to 0x034 takes transition `T_OPEN`. Any other value written to 0x034 leaves the unit locked. Once open, the unit stays open until reset.
- R3: Control bits 14:13 always read 1 whatever is written, and the other control bits read back as written. `prog_n` follows control bit 30 and `cfg_port_sel` follows control bit 26.
- R4: A rising edge on `init_in` sets interrupt status bit 1, a falling edge sets bit 0, and a rising edge on `done_in` sets bit 2. The bit is readable one clock edge after the new level is sampled.
- R5: `dma_done_evt` sets bit 13 and `cfg_port_done_evt` sets bit 12. `xfer_err_evt[3:0]` sets bits 23:20, and `fifo_ovf_evt` sets bit 18.
- R6: Writing 1 to an interrupt status bit clears it, and writing 0 leaves it unchanged.
- R7: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R8: `irq` is high exactly when some status bit is set whose mask bit is 0, so a mask bit of 1 disables its source.
- R9: Only the bits in 0xF8F7F87F can be set. `misc_evt` is bit-aligned with the status register and sets any implemented bit. Every other bit reads 0.
- R10: Offset 0x014 reads `cmdq_full` in bit 31, `cmdq_empty` in bit 30, the live `init_in` level in bit 4, and 0 elsewhere. Unmapped offsets, including 0x034, read 0.
- R11: `err_any` is high when any status bit in the error group 0x00F0F860 is set, regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| init_in | input | 1 | Fabric init line (level) |
| done_in | input | 1 | Fabric done line (level) |
| dma_done_evt | input | 1 | DMA transfer finished pulse |
| cfg_port_done_evt | input | 1 | DMA finished and configuration port drained pulse |
| xfer_err_evt | input | 4 | Bus read/write error and timeout pulses |
| fifo_ovf_evt | input | 1 | Receive FIFO overflow pulse |
| misc_evt | input | 32 | Other event pulses, aligned with status bits |
| cmdq_full | input | 1 | DMA command queue full flag |
| cmdq_empty | input | 1 | DMA command queue empty flag |
| prog_n | output | 1 | Active-low program line (control bit 30) |
| cfg_port_sel | output | 1 | Configuration-port mode select (control bit 26) |
| irq | output | 1 | Level interrupt |
| err_any | output | 1 | Any error-group status bit set |

## Verification
A lock machine stuck in the wrong state shows up at the first write after reset. If it is wrongly open, a control or mask write before unlock reads back changed. If it is wrongly shut, a write after unlock is lost. Either way the fault is visible on the next read, with no extra delay. A corrupt status or mask register shows at `irq` and `err_any` in the same cycle as the register, because both outputs are plain combinations of stored state. A wrong edge-detector history bit produces a spurious or missing status bit one clock edge after the line changes.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam int DW = 32;

    // Register byte offsets
    localparam int OFF_CTRL   = 'h000;
    localparam int OFF_ISTAT  = 'h00C;
    localparam int OFF_IMASK  = 'h010;
    localparam int OFF_STAT   = 'h014;
    localparam int OFF_UNLOCK = 'h034;

    localparam logic [DW-1:0] UNLOCK_KEY  = 32'h757B_DF0D;
    localparam logic [DW-1:0] ISTAT_IMPL  = 32'hF8F7_F87F;
    localparam logic [DW-1:0] ISTAT_ERR   = 32'h00F0_F860;
    localparam logic [DW-1:0] CTRL_ONES   = 32'h0000_6000;
    localparam logic [DW-1:0] CTRL_RST    = CTRL_ONES;
    localparam logic [DW-1:0] IMASK_RST   = '1;

    // Control bit positions
    localparam int CB_PROG_N  = 30;
    localparam int CB_PORTSEL = 26;

    // Interrupt status bit positions
    localparam int IB_INIT_FALL = 0;
    localparam int IB_INIT_RISE = 1;
    localparam int IB_DONE_RISE = 2;
    localparam int IB_PORT_DONE = 12;
    localparam int IB_DMA_DONE  = 13;
    localparam int IB_FIFO_OVF  = 18;
    localparam int IB_XERR_LO   = 20;
    localparam int XERR_W       = 4;

    // Status word bit positions
    localparam int SB_QFULL  = 31;
    localparam int SB_QEMPTY = 30;
    localparam int SB_INIT   = 4;

    typedef enum logic [0:0] {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_st_e;

endpackage

// File: rtl/cfgreg_lock_fsm.sv
module cfgreg_lock_fsm
    import cfgreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit,
    output logic wr_open
);

    lock_st_e state_q;
    lock_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (key_hit) state_d = LK_OPEN;   // T_OPEN
            LK_OPEN: state_d = LK_OPEN;                // T_STAY
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_open = 1'b0;
        unique case (state_q)
            LK_SHUT: wr_open = 1'b0;
            LK_OPEN: wr_open = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfgreg_edge.sv
module cfgreg_edge #(
    parameter int          N         = 3,
    parameter logic [N-1:0] RISE_SEL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] hit
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (RISE_SEL[i]) begin : g_rise
            assign hit[i] = lvl[i] & ~prev_q[i];
        end else begin : g_fall
            assign hit[i] = ~lvl[i] & prev_q[i];
        end
    end

endmodule

// File: rtl/cfgreg_istat.sv
module cfgreg_istat #(
    parameter int          W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat_q
);

    logic [W-1:0] stat_d;

    // Set dominates clear so an event in the clearing cycle is not lost.
    always_comb begin
        stat_d = ((stat_q & ~clr_vec) | set_vec) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

endmodule

// File: rtl/cfgreg_unit.sv
module cfgreg_unit
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              init_in,
    input  logic              done_in,
    input  logic              dma_done_evt,
    input  logic              cfg_port_done_evt,
    input  logic [XERR_W-1:0] xfer_err_evt,
    input  logic              fifo_ovf_evt,
    input  logic [DW-1:0]     misc_evt,
    input  logic              cmdq_full,
    input  logic              cmdq_empty,
    output logic              prog_n,
    output logic              cfg_port_sel,
    output logic              irq,
    output logic              err_any
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_ISTAT  = ADDR_W'(OFF_ISTAT);
    localparam logic [ADDR_W-1:0] A_IMASK  = ADDR_W'(OFF_IMASK);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFF_UNLOCK);
    localparam int                N_EDGE   = 3;

    logic              lock_open;
    logic              key_hit;
    logic              wr_ok;
    logic [DW-1:0]     ctrl_q;
    logic [DW-1:0]     mask_q;
    logic [DW-1:0]     istat_q;
    logic [DW-1:0]     set_vec;
    logic [DW-1:0]     clr_vec;
    logic [DW-1:0]     stat_word;
    logic [N_EDGE-1:0] edge_hit;

    // ---------------- write decode ----------------
    assign key_hit = bus_we && (bus_addr == A_UNLOCK) && (bus_wdata == UNLOCK_KEY);
    assign wr_ok   = bus_we && lock_open;

    cfgreg_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_hit (key_hit),
        .wr_open (lock_open)
    );

    // ---------------- edge capture ----------------
    // bit 0: init fall, bit 1: init rise, bit 2: done rise
    cfgreg_edge #(
        .N        (N_EDGE),
        .RISE_SEL (3'b110)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({done_in, init_in, init_in}),
        .hit   (edge_hit)
    );

    always_comb begin
        set_vec = misc_evt;
        set_vec[IB_INIT_FALL] = set_vec[IB_INIT_FALL] | edge_hit[0];
        set_vec[IB_INIT_RISE] = set_vec[IB_INIT_RISE] | edge_hit[1];
        set_vec[IB_DONE_RISE] = set_vec[IB_DONE_RISE] | edge_hit[2];
        set_vec[IB_PORT_DONE] = set_vec[IB_PORT_DONE] | cfg_port_done_evt;
        set_vec[IB_DMA_DONE]  = set_vec[IB_DMA_DONE]  | dma_done_evt;
        set_vec[IB_FIFO_OVF]  = set_vec[IB_FIFO_OVF]  | fifo_ovf_evt;
        set_vec[IB_XERR_LO +: XERR_W] = set_vec[IB_XERR_LO +: XERR_W] | xfer_err_evt;
    end

    assign clr_vec = (wr_ok && bus_addr == A_ISTAT) ? bus_wdata : '0;

    cfgreg_istat #(
        .W    (DW),
        .IMPL (ISTAT_IMPL)
    ) u_istat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat_q  (istat_q)
    );

    // ---------------- control and mask ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            mask_q <= IMASK_RST;
        end else if (wr_ok) begin
            if (bus_addr == A_CTRL)  ctrl_q <= bus_wdata | CTRL_ONES;
            if (bus_addr == A_IMASK) mask_q <= bus_wdata;
        end
    end

    // ---------------- read path ----------------
    always_comb begin
        stat_word            = '0;
        stat_word[SB_QFULL]  = cmdq_full;
        stat_word[SB_QEMPTY] = cmdq_empty;
        stat_word[SB_INIT]   = init_in;
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_ISTAT: bus_rdata = istat_q;
            A_IMASK: bus_rdata = mask_q;
            A_STAT:  bus_rdata = stat_word;
            default: bus_rdata = '0;
        endcase
    end

    // ---------------- outputs ----------------
    assign prog_n       = ctrl_q[CB_PROG_N];
    assign cfg_port_sel = ctrl_q[CB_PORTSEL];
    assign irq          = |(istat_q & ~mask_q);
    assign err_any      = |(istat_q & ISTAT_ERR);

endmodule

// File: rtl/cfgreg_checker.sv
module cfgreg_checker
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [1:0]        rd_resv,
    input logic              init_in,
    input logic              dma_done_evt,
    input logic              misc13,
    input logic              irq,
    input logic              lock_open,
    input logic [DW-1:0]     ctrl_q,
    input logic [DW-1:0]     mask_q,
    input logic              ist_init_rise,
    input logic              ist_dma
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_ISTAT  = ADDR_W'(OFF_ISTAT);
    localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFF_UNLOCK);

    p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_open && bus_we) |=> ($stable(ctrl_q) && $stable(mask_q)));

    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_open && bus_we && bus_addr == A_UNLOCK && bus_wdata == UNLOCK_KEY) |=> lock_open);

    p_stay_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_open |=> lock_open);

    p_resv_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (rd_resv == 2'b11));

    p_init_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_in) |=> ist_init_rise);

    p_dma_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done_evt |=> ist_dma);

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_open && bus_we && bus_addr == A_ISTAT && bus_wdata[IB_DMA_DONE]
         && !dma_done_evt && !misc13) |=> !ist_dma);

    p_mask_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);

endmodule

bind cfgreg_unit cfgreg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .rd_resv       (bus_rdata[14:13]),
    .init_in       (init_in),
    .dma_done_evt  (dma_done_evt),
    .misc13        (misc_evt[13]),
    .irq           (irq),
    .lock_open     (lock_open),
    .ctrl_q        (ctrl_q),
    .mask_q        (mask_q),
    .ist_init_rise (istat_q[1]),
    .ist_dma       (istat_q[13])
);

// File: tb/sim_cfgreg_unit.sv
`timescale 1ns/1ps
module sim_cfgreg_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        init_in = 1'b0;
    logic        done_in = 1'b0;
    logic        dma_done_evt = 1'b0;
    logic        cfg_port_done_evt = 1'b0;
    logic [3:0]  xfer_err_evt = '0;
    logic        fifo_ovf_evt = 1'b0;
    logic [31:0] misc_evt = '0;
    logic        cmdq_full = 1'b0;
    logic        cmdq_empty = 1'b0;
    logic        prog_n, cfg_port_sel, irq, err_any;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfgreg_unit #(.ADDR_W(8)) u0 (.*);

    // op: 0 = write, 1 = read and compare
    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] val;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [0:NV-1] = '{
        '{2'd1, 8'h00, 32'h0000_6000, 8'd1},   // R1 ctrl reset
        '{2'd1, 8'h0C, 32'h0000_0000, 8'd1},   // R1 istat reset
        '{2'd1, 8'h10, 32'hFFFF_FFFF, 8'd1},   // R1 mask reset
        '{2'd0, 8'h00, 32'h4400_0000, 8'd2},   // R2 locked write
        '{2'd1, 8'h00, 32'h0000_6000, 8'd2},
        '{2'd0, 8'h10, 32'h0000_0000, 8'd2},
        '{2'd1, 8'h10, 32'hFFFF_FFFF, 8'd2},
        '{2'd0, 8'h34, 32'h1234_5678, 8'd2},   // R2 wrong key
        '{2'd0, 8'h10, 32'h0000_0000, 8'd2},
        '{2'd1, 8'h10, 32'hFFFF_FFFF, 8'd2},
        '{2'd0, 8'h34, 32'h757B_DF0D, 8'd2},   // R2 right key
        '{2'd0, 8'h00, 32'h4400_0000, 8'd3},   // R3
        '{2'd1, 8'h00, 32'h4400_6000, 8'd3},
        '{2'd0, 8'h00, 32'h0000_0000, 8'd3},
        '{2'd1, 8'h00, 32'h0000_6000, 8'd3},
        '{2'd0, 8'h00, 32'hFFFF_9FFF, 8'd3},
        '{2'd1, 8'h00, 32'hFFFF_FFFF, 8'd3},
        '{2'd0, 8'h10, 32'h0000_F0F0, 8'd2},   // R2 open write
        '{2'd1, 8'h10, 32'h0000_F0F0, 8'd2},
        '{2'd1, 8'h34, 32'h0000_0000, 8'd10}   // R10 unlock reads 0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdc(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {31'd0, irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].op == 2'd0) wr(VT[i].addr, VT[i].val);
            else rdc($sformatf("R%0d vec%0d", VT[i].req, i), VT[i].addr, VT[i].val);
        end

        // R3 control outputs
        wr(8'h00, 32'h4400_0000);
        check("R3 prog_n", {31'd0, prog_n}, 32'd1);
        check("R3 cfg_port_sel", {31'd0, cfg_port_sel}, 32'd1);
        wr(8'h00, 32'h0000_0000);
        check("R3 prog_n low", {30'd0, prog_n, cfg_port_sel}, 32'd0);

        // R4 edges, mask all
        wr(8'h10, 32'hFFFF_FFFF);
        init_in = 1'b1; tick;
        rdc("R4 init rise", 8'h0C, 32'h2);
        check("R8 masked irq", {31'd0, irq}, 32'd0);
        init_in = 1'b0; tick;
        rdc("R4 init fall", 8'h0C, 32'h3);
        done_in = 1'b1; tick;
        rdc("R4 done rise", 8'h0C, 32'h7);

        // R6 write-1-to-clear
        wr(8'h0C, 32'h1);
        rdc("R6 clear bit0", 8'h0C, 32'h6);
        wr(8'h0C, 32'h0);
        rdc("R6 zero no effect", 8'h0C, 32'h6);
        wr(8'h0C, 32'hFFFF_FFFF);
        rdc("R6 clear all", 8'h0C, 32'h0);

        // R5 internal events, R11 error group
        dma_done_evt = 1'b1; cfg_port_done_evt = 1'b1; xfer_err_evt = 4'hF; fifo_ovf_evt = 1'b1;
        tick;
        dma_done_evt = 1'b0; cfg_port_done_evt = 1'b0; xfer_err_evt = 4'h0; fifo_ovf_evt = 1'b0;
        rdc("R5 event bits", 8'h0C, 32'h00F4_3000);
        check("R11 err_any set", {31'd0, err_any}, 32'd1);
        wr(8'h0C, 32'hFFFF_FFFF);
        fifo_ovf_evt = 1'b1; tick; fifo_ovf_evt = 1'b0;
        rdc("R5 fifo ovf", 8'h0C, 32'h0004_0000);
        check("R11 err_any not in group", {31'd0, err_any}, 32'd0);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R9 implemented bits only
        misc_evt = 32'hFFFF_FFFF; tick; misc_evt = '0;
        rdc("R9 implemented set", 8'h0C, 32'hF8F7_F87F);
        wr(8'h0C, 32'hFFFF_FFFF);
        rdc("R9 cleared", 8'h0C, 32'h0);

        // R7 event beats clear
        dma_done_evt = 1'b1; tick; dma_done_evt = 1'b0;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h2000; dma_done_evt = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; dma_done_evt = 1'b0;
        rdc("R7 event wins", 8'h0C, 32'h2000);

        // R8 interrupt masking
        check("R8 masked", {31'd0, irq}, 32'd0);
        wr(8'h10, 32'hFFFF_DFFF);
        check("R8 unmasked", {31'd0, irq}, 32'd1);
        wr(8'h10, 32'hFFFF_FFFE);
        check("R8 other source", {31'd0, irq}, 32'd0);
        wr(8'h0C, 32'h2000);
        wr(8'h10, 32'h0);
        check("R8 none set", {31'd0, irq}, 32'd0);

        // R10 status word
        cmdq_full = 1'b1; cmdq_empty = 1'b0; init_in = 1'b1;
        rdc("R10 status a", 8'h14, 32'h8000_0010);
        cmdq_full = 1'b0; cmdq_empty = 1'b1; init_in = 1'b0;
        rdc("R10 status b", 8'h14, 32'h4000_0000);
        rdc("R10 unmapped", 8'h08, 32'h0);
        tick; tick;

        // R1 R2 reset returns to locked
        wr(8'h00, 32'h4400_0000);
        @(negedge clk); rst_n = 1'b0;
        done_in = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        rdc("R1 ctrl after reset", 8'h00, 32'h6000);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        wr(8'h10, 32'h0);
        rdc("R2 relocked", 8'h10, 32'hFFFF_FFFF);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule